// File: doc/BRIEF.md
# Two-Stage Attack and Hold Pulse Sequencer

This block drives an actuator coil in two phases. A start strobe raises the attack output. The attack lasts for a programmed number of ticks. That length is a count of whole timer periods (coarse) plus one short tail (fine). When the attack ends, the block moves to a hold phase. The hold phase is either a steady hold level or an enable for an external PWM generator, and a mode input picks which one. A stop strobe ends the hold.

The timer tick comes from the system clock through a selectable power-of-two divider. Coarse value, fine value and divider select sit in a small settings register. A load strobe updates that register, and reset fills it with defaults. A repeat mode makes the sequencer free-run. Each time the fine phase ends it restarts, the attack level flips, and the PWM enable is forced on. This is useful for watching the timing on a bench indicator.

Top module: `attack_hold_seq`

## Requirements
- R1: After reset, attack_o, hold_o, pwm_en_o and both flags are low. The settings register holds RST_COARSE, RST_FINE and RST_PRESC (defaults 245, 25 and 4).
- R2: A cycle with cfg_load_i high copies coarse_i, fine_i and presc_i into the settings register. Every later tick decision uses the new values.
- R3: The prescale select values 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. Any other value gives no ticks, so a running sequence freezes in place.
- R4: When start_i is high and stop_i is low, attack_o is high after that edge, and hold_o and pwm_en_o are low. The timer restarts from zero. This also applies when a sequence is already running.
- R5: Let C be the coarse value, F the fine value, P = 2^PERIOD_BITS and D the divider. attack_o falls (C*P + F + 1)*D clocks after the start edge. A coarse value of 0 skips the coarse phase.
- R6: When the fine phase ends with repeat_i low, attack_o goes low. pwm_en_o goes high if pwm_hold_i is high, otherwise hold_o goes high. The timer then stays stopped.
- R7: When the fine phase ends with repeat_i high, the sequence restarts at once. attack_o takes the inverse of its previous level and pwm_en_o goes high.
- R8: stop_i stops the timer and drives hold_o and pwm_en_o low at the next edge. attack_o is left unchanged. stop_i takes precedence over a simultaneous start_i.
- R9: flag_attack_o follows attack_o. flag_hold_o is high whenever hold_o or pwm_en_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Load strobe for the settings register |
| coarse_i | input | CNT_W | Number of full timer periods in the attack |
| fine_i | input | CNT_W | Fine tail length minus one, in ticks |
| presc_i | input | 3 | Tick divider select |
| repeat_i | input | 1 | Free-running repeat mode |
| pwm_hold_i | input | 1 | Hold with the PWM enable instead of the steady level |
| start_i | input | 1 | Note-on strobe |
| stop_i | input | 1 | Note-off strobe |
| attack_o | output | 1 | Attack drive level |
| hold_o | output | 1 | Steady hold level |
| pwm_en_o | output | 1 | Enable for the external hold PWM |
| flag_attack_o | output | 1 | Attack state flag |
| flag_hold_o | output | 1 | Hold state flag |

## Verification
The bench builds the block with PERIOD_BITS=2 and reset defaults of coarse 3, fine 2 and prescale 4. With these values, a sequence that runs only on the reset settings ends after 3840 clocks. This keeps the default path and a multi-period coarse phase at the 256-clock divider within a short run. The short period also lets loaded settings cover every listed divider, the zero-coarse path, a zero fine value and retriggering at exact edge counts.

// File: rtl/attack_hold_seq.sv
module attack_hold_seq #(
  parameter int CNT_W       = 8,
  parameter int PERIOD_BITS = 8,
  parameter int RST_COARSE  = 245,
  parameter int RST_FINE    = 25,
  parameter int RST_PRESC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load_i,
  input  logic [CNT_W-1:0] coarse_i,
  input  logic [CNT_W-1:0] fine_i,
  input  logic [2:0]       presc_i,
  input  logic             repeat_i,
  input  logic             pwm_hold_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             attack_o,
  output logic             hold_o,
  output logic             pwm_en_o,
  output logic             flag_attack_o,
  output logic             flag_hold_o
);
  localparam int PC_W = 10;
  localparam logic [CNT_W-1:0] PERIOD_LAST = CNT_W'((1 << PERIOD_BITS) - 1);

  typedef enum logic [1:0] {S_IDLE, S_COARSE, S_FINE} st_t;

  st_t             st;
  logic [CNT_W-1:0] coarse_q, fine_q, tc, cc;
  logic [2:0]      presc_q;
  logic [PC_W-1:0] pc, mask;
  logic            valid, tick, start_go, coarse_done, fine_done;
  st_t             first_st;

  always_comb begin
    valid = 1'b1;
    case (presc_q)
      3'd1:    mask = 10'h000;
      3'd2:    mask = 10'h007;
      3'd3:    mask = 10'h03F;
      3'd4:    mask = 10'h0FF;
      3'd5:    mask = 10'h3FF;
      default: begin mask = 10'h000; valid = 1'b0; end
    endcase
  end

  assign tick        = (st != S_IDLE) && valid && ((pc & mask) == mask);
  assign start_go    = start_i && !stop_i;
  assign first_st    = (coarse_q != '0) ? S_COARSE : S_FINE;
  assign coarse_done = ({1'b0, cc} + 1'b1) >= {1'b0, coarse_q};
  assign fine_done   = (tc == fine_q);

  assign flag_attack_o = attack_o;
  assign flag_hold_o   = hold_o | pwm_en_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      coarse_q <= CNT_W'(RST_COARSE);
      fine_q   <= CNT_W'(RST_FINE);
      presc_q  <= 3'(RST_PRESC);
      tc       <= '0;
      cc       <= '0;
      pc       <= '0;
      attack_o <= 1'b0;
      hold_o   <= 1'b0;
      pwm_en_o <= 1'b0;
    end else begin
      if (cfg_load_i) begin
        coarse_q <= coarse_i;
        fine_q   <= fine_i;
        presc_q  <= presc_i;
      end
      pc <= pc + 1'b1;
      if (stop_i) begin
        st       <= S_IDLE;
        hold_o   <= 1'b0;
        pwm_en_o <= 1'b0;
      end else if (start_go) begin
        st       <= first_st;
        tc       <= '0;
        cc       <= '0;
        pc       <= '0;
        attack_o <= 1'b1;
        hold_o   <= 1'b0;
        pwm_en_o <= 1'b0;
      end else if (tick) begin
        case (st)
          S_COARSE: begin
            if (tc == PERIOD_LAST) begin
              tc <= '0;
              if (coarse_done) st <= S_FINE;
              else             cc <= cc + 1'b1;
            end else begin
              tc <= tc + 1'b1;
            end
          end
          S_FINE: begin
            if (fine_done) begin
              if (repeat_i) begin
                st       <= first_st;
                tc       <= '0;
                cc       <= '0;
                pc       <= '0;
                attack_o <= ~attack_o;
                pwm_en_o <= 1'b1;
              end else begin
                st       <= S_IDLE;
                attack_o <= 1'b0;
                if (pwm_hold_i) pwm_en_o <= 1'b1;
                else            hold_o   <= 1'b1;
              end
            end else begin
              tc <= tc + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module attack_hold_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input logic attack_o,
  input logic hold_o,
  input logic pwm_en_o
);
  AST_START_RAISES_ATTACK: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (attack_o && !hold_o && !pwm_en_o)); // R4
  AST_STOP_DROPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!hold_o && !pwm_en_o)); // R8
  AST_STOP_KEEPS_ATTACK: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (attack_o == $past(attack_o))); // R8
  AST_FALL_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(attack_o) |-> (hold_o || pwm_en_o)); // R6
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attack_o) |-> ($past(start_i) || pwm_en_o)); // R7
  AST_HOLD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_o && pwm_en_o)); // R6
endmodule

bind attack_hold_seq attack_hold_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .attack_o(attack_o), .hold_o(hold_o), .pwm_en_o(pwm_en_o)
);

// File: tb/attack_hold_seq_test.sv
module attack_hold_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load_i = 0, repeat_i = 0, pwm_hold_i = 0, start_i = 0, stop_i = 0;
  logic [7:0] coarse_i = 0, fine_i = 0;
  logic [2:0] presc_i = 0;
  logic attack_o, hold_o, pwm_en_o, flag_attack_o, flag_hold_o;

  int checks = 0, fails = 0, cyc = 0;

  typedef struct { int at; logic a; logic h; logic p; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  attack_hold_seq #(.CNT_W(8), .PERIOD_BITS(2), .RST_COARSE(3), .RST_FINE(2), .RST_PRESC(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load_i), .coarse_i(coarse_i), .fine_i(fine_i),
    .presc_i(presc_i), .repeat_i(repeat_i), .pwm_hold_i(pwm_hold_i), .start_i(start_i),
    .stop_i(stop_i), .attack_o(attack_o), .hold_o(hold_o), .pwm_en_o(pwm_en_o),
    .flag_attack_o(flag_attack_o), .flag_hold_o(flag_hold_o));

  task automatic compare(string tag, logic a, logic h, logic p);
    checks++;
    if (attack_o !== a || hold_o !== h || pwm_en_o !== p ||
        flag_attack_o !== a || flag_hold_o !== (h | p)) begin
      fails++;
      $display("FAIL %s (R9 flags incl.) cyc=%0d actual a=%b h=%b p=%b fa=%b fh=%b expected a=%b h=%b p=%b fa=%b fh=%b",
               tag, cyc, attack_o, hold_o, pwm_en_o, flag_attack_o, flag_hold_o, a, h, p, a, h | p);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      compare(e.tag, e.a, e.h, e.p);
    end
  end

  task automatic expect_at(int at, logic a, logic h, logic p, string tag);
    exp_t e;
    e.at = at; e.a = a; e.h = h; e.p = p; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic load(int c, int f, int ps);
    @(negedge clk);
    cfg_load_i = 1; coarse_i = 8'(c); fine_i = 8'(f); presc_i = 3'(ps);
    @(negedge clk);
    cfg_load_i = 0;
  endtask

  task automatic pulse(logic st, logic sp, output int s);
    @(negedge clk);
    start_i = st; stop_i = sp; s = cyc + 1;
    @(negedge clk);
    start_i = 0; stop_i = 0;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int s, s2;
    logic ab;
    repeat (3) @(negedge clk);
    compare("R1 reset outputs", 0, 0, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 defaults: coarse 3, fine 2, select 4 -> (3*4+3)*256 = 3840
    pulse(1, 0, s);
    expect_at(s, 1, 0, 0, "R4 start");
    expect_at(s + 3839, 1, 0, 0, "R1 default length");
    expect_at(s + 3840, 0, 1, 0, "R1 R5 R6 default end steady hold");
    drain();

    pulse(0, 1, s);
    expect_at(s, 0, 0, 0, "R8 stop clears hold");
    drain();

    // R2 R3 divider 1, coarse 0, fine 0, PWM hold
    pwm_hold_i = 1;
    load(0, 0, 1);
    pulse(1, 0, s);
    expect_at(s, 1, 0, 0, "R4 start");
    expect_at(s + 1, 0, 0, 1, "R5 R6 one-tick fine phase, PWM hold");
    expect_at(s + 5, 0, 0, 1, "R6 timer stopped");
    drain();
    pulse(0, 1, s);
    expect_at(s, 0, 0, 0, "R8 stop clears pwm enable");
    drain();
    pwm_hold_i = 0;

    // divider 8: (2*4+6)*8 = 112
    load(2, 5, 2);
    pulse(1, 0, s);
    expect_at(s + 111, 1, 0, 0, "R5 coarse+fine length div8");
    expect_at(s + 112, 0, 1, 0, "R2 R3 end div8");
    drain();

    // divider 64, coarse skipped: 4*64 = 256; start clears hold
    load(0, 3, 3);
    pulse(1, 0, s);
    expect_at(s, 1, 0, 0, "R4 start clears hold");
    expect_at(s + 255, 1, 0, 0, "R5 zero coarse length");
    expect_at(s + 256, 0, 1, 0, "R3 div64 end");
    drain();

    // retrigger: N = 1*4+1 = 5
    load(1, 0, 1);
    pulse(1, 0, s);
    repeat (1) @(negedge clk);
    pulse(1, 0, s2);
    expect_at(s2 + 4, 1, 0, 0, "R4 retrigger restarts count");
    expect_at(s2 + 5, 0, 1, 0, "R4 retrigger end");
    drain();

    // repeat mode: N = 2
    repeat_i = 1;
    load(0, 1, 1);
    pulse(1, 0, s);
    expect_at(s, 1, 0, 0, "R4 start");
    expect_at(s + 2, 0, 0, 1, "R7 toggle low, pwm forced");
    expect_at(s + 3, 0, 0, 1, "R7 between restarts");
    expect_at(s + 4, 1, 0, 1, "R7 toggle high");
    expect_at(s + 6, 0, 0, 1, "R7 toggle low again");
    drain();
    @(negedge clk);
    ab = attack_o;
    pulse(0, 1, s);
    expect_at(s, ab, 0, 0, "R8 stop in repeat mode");
    expect_at(s + 4, ab, 0, 0, "R8 timer halted");
    drain();
    repeat_i = 0;

    // invalid select: frozen
    load(1, 0, 0);
    pulse(1, 0, s);
    expect_at(s, 1, 0, 0, "R4 start");
    expect_at(s + 60, 1, 0, 0, "R3 select 0 gives no ticks");
    drain();
    pulse(0, 1, s);
    expect_at(s, 1, 0, 0, "R8 stop leaves attack");
    expect_at(s + 3, 1, 0, 0, "R8 attack held after stop");
    drain();

    // stop beats start
    load(0, 0, 1);
    pulse(1, 0, s);
    expect_at(s + 1, 0, 1, 0, "R6 steady hold");
    drain();
    pulse(1, 1, s);
    expect_at(s, 0, 0, 0, "R8 stop wins over start");
    expect_at(s + 3, 0, 0, 0, "R8 no sequence started");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule